// File: doc/BRIEF.md
# MAC Interrupt Status and Enable

This block sits between the event sources of an Ethernet MAC and the host. Eight single-cycle event pulses come from the receive engine, the transmit engine, the statistics counters and the PHY link monitor. Each pulse sets a fixed bit in a 16-bit pending register. A 16-bit enable register selects which pending bits may drive one level-sensitive interrupt line towards the host.

The host services an interrupt in two steps. It reads the pending register, and then it writes the same value back. A write clears every bit that holds a 1 in the written data and leaves every other bit alone. An event that arrives after the read therefore survives the write-back and keeps the line asserted. Writing zero to the enable register silences the line, and pending bits keep latching while it is silenced.

Top module: `mac_irq_ctrl`

## Requirements
- R1: Synchronous active-low reset clears the pending and enable registers to zero, and `irq_o` is low while they are zero.
- R2: An event pulse sets its pending bit on the next clock edge. The bit positions are: receive done bit 0, no receive descriptor bit 1, receive FIFO full bit 2, receive early bit 3, transmit done bit 4, transmit early bit 7, counter overflow bit 8 and link change bit 9. A set bit stays set until it is cleared.
- R3: Pending bits latch whatever the enable register holds, and a pending bit whose enable bit is 0 does not raise `irq_o`.
- R4: A write to the pending register at offset 0x3C clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: When an event arrives in the same cycle as a write that clears its bit, the bit stays set.
- R6: `irq_o` is the OR over all bits of pending AND enable. It goes high in the cycle after an enable write (offset 0x40) that enables a bit already pending, or after an event whose bit is enabled.
- R7: Bits 5, 6 and 10 to 15 are not implemented in either register. They read as 0, and writes to them are ignored.
- R8: Writing 0 to the enable register drops `irq_o` on the next cycle and leaves the pending bits as they are.
- R9: A read from any offset other than 0x3C and 0x40 returns 0, and a write to such an offset changes neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_rx_done | input | 1 | Receive done pulse |
| ev_rx_nodesc | input | 1 | No receive descriptor pulse |
| ev_rx_full | input | 1 | Receive FIFO full pulse |
| ev_rx_early | input | 1 | Receive early pulse |
| ev_tx_done | input | 1 | Transmit done pulse |
| ev_tx_early | input | 1 | Transmit early pulse |
| ev_cnt_ovf | input | 1 | Event counter overflow pulse |
| ev_link_chg | input | 1 | PHY link change pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on `reg_addr`) |
| irq_o | output | 1 | Level-sensitive interrupt request |

## Verification
The assertions check on every cycle that:
- an event reaches its pending bit;
- a pending bit drops only when a 1 is written to it;
- a cleared bit stays clear unless an event arrived in the same cycle;
- unimplemented bits read as zero;
- the enable register changes only on its own write;
- a zero write to the enable register silences the line.

The following can only be shown by the bench's scenarios:
- the exact bit map of the event inputs;
- the read-then-write-back handshake when an event lands between the read and the write;
- the line rising as soon as a bit that is already pending is enabled;
- writes to unused offsets having no effect.

// File: rtl/mac_irq_pkg.sv
// Shared constants for the MAC interrupt controller.
// Assumes a fixed map of eight event sources into a 16-bit register.
package mac_irq_pkg;

    localparam int REG_W   = 16;
    localparam int NUM_EVT = 8;

    // Bit position of each event source, indexed by event number.
    function automatic int evt_pos(input int idx);
        case (idx)
            0:       return 0;  // receive done
            1:       return 1;  // no receive descriptor
            2:       return 2;  // receive FIFO full
            3:       return 3;  // receive early
            4:       return 4;  // transmit done
            5:       return 7;  // transmit early
            6:       return 8;  // counter overflow
            default: return 9;  // link change
        endcase
    endfunction

    // Mask of the implemented bits, derived from the event map.
    function automatic logic [REG_W-1:0] build_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_EVT; i++) begin
            m[evt_pos(i)] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [REG_W-1:0] IMPL_MASK = build_mask();

endpackage

// File: rtl/mac_irq_event_map.sv
// Places the event pulses onto their fixed bit positions.
// Assumes each event is a single-cycle pulse synchronous to clk.
module mac_irq_event_map
    import mac_irq_pkg::*;
(
    input  logic [NUM_EVT-1:0] evt_i,
    output logic [REG_W-1:0]   set_o
);

    // Scatter each event pulse onto its register bit.
    always_comb begin
        set_o = '0;
        for (int i = 0; i < NUM_EVT; i++) begin
            set_o[evt_pos(i)] = evt_i[i];
        end
    end

endmodule

// File: rtl/mac_irq_status.sv
// Pending register: write-one-to-clear, and a set wins over a clear.
// Assumes that set_i and clr_i are valid for one cycle each.
module mac_irq_status #(
    parameter int               W    = 16,
    parameter logic [W-1:0]     MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] status_o
);

    logic [W-1:0] status_q;

    // Update the pending bits: clear the written ones, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= ((status_q & ~clr_i) | set_i) & MASK;
        end
    end

    assign status_o = status_q;

    // An event reaches its implemented pending bit on the next edge.
    assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(set_i & MASK)) == $past(set_i & MASK)));

    // A bit that was not written with a 1 never drops.
    assert_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status_q) & ~$past(clr_i) & ~status_q) == '0));

    // A cleared bit stays clear unless an event came in the same cycle.
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(clr_i) & ~$past(set_i)) == '0));

endmodule

// File: rtl/mac_irq_enable.sv
// Enable register: loaded as a whole on a write, with unimplemented bits forced to 0.
// Assumes a single write strobe and full-width data.
module mac_irq_enable #(
    parameter int           W    = 16,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] enable_o
);

    logic [W-1:0] enable_q;

    // Load the enable mask on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (wr_i) begin
            enable_q <= wdata_i & MASK;
        end
    end

    assign enable_o = enable_q;

    // Without a write the mask does not change.
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(enable_q));

endmodule

// File: rtl/mac_irq_combine.sv
// Reduces pending AND enable to a single interrupt level.
// Assumes both inputs come from registers, so the output is glitch-free per cycle.
module mac_irq_combine #(
    parameter int W = 16
) (
    input  logic [W-1:0] status_i,
    input  logic [W-1:0] enable_i,
    output logic         irq_o
);

    // Request an interrupt when any enabled bit is pending.
    always_comb begin
        irq_o = |(status_i & enable_i);
    end

endmodule

// File: rtl/mac_irq_ctrl.sv
// Top level of the MAC interrupt status/enable block: register decode, read
// mux and the interrupt line. Assumes a simple single-cycle register port with
// a combinational read.
module mac_irq_ctrl
    import mac_irq_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] STAT_OFS  = 8'h3C,
    parameter logic [ADDR_W-1:0] ENAB_OFS  = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_rx_done,
    input  logic              ev_rx_nodesc,
    input  logic              ev_rx_full,
    input  logic              ev_rx_early,
    input  logic              ev_tx_done,
    input  logic              ev_tx_early,
    input  logic              ev_cnt_ovf,
    input  logic              ev_link_chg,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq_o
);

    logic [NUM_EVT-1:0] evt_vec;
    logic [REG_W-1:0]   set_vec;
    logic [REG_W-1:0]   clr_vec;
    logic [REG_W-1:0]   status;
    logic [REG_W-1:0]   enable;
    logic               hit_stat;
    logic               hit_enab;
    logic               enab_wr;

    // Gather the event pulses in event-number order.
    assign evt_vec = {ev_link_chg, ev_cnt_ovf, ev_tx_early, ev_tx_done,
                      ev_rx_early, ev_rx_full, ev_rx_nodesc, ev_rx_done};

    // Decode the register offsets.
    always_comb begin
        hit_stat = (reg_addr == STAT_OFS);
        hit_enab = (reg_addr == ENAB_OFS);
        enab_wr  = reg_wr && hit_enab;
        clr_vec  = (reg_wr && hit_stat) ? reg_wdata : '0;
    end

    mac_irq_event_map u_map (
        .evt_i (evt_vec),
        .set_o (set_vec)
    );

    mac_irq_status #(.W(REG_W), .MASK(IMPL_MASK)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_vec),
        .clr_i    (clr_vec),
        .status_o (status)
    );

    mac_irq_enable #(.W(REG_W), .MASK(IMPL_MASK)) u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (enab_wr),
        .wdata_i  (reg_wdata),
        .enable_o (enable)
    );

    mac_irq_combine #(.W(REG_W)) u_combine (
        .status_i (status),
        .enable_i (enable),
        .irq_o    (irq_o)
    );

    // Return the selected register, or 0 for an unused offset.
    always_comb begin
        if (hit_stat)      reg_rdata = status;
        else if (hit_enab) reg_rdata = enable;
        else               reg_rdata = '0;
    end

    // Unimplemented bits never appear on the read port.
    assert_unimpl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~IMPL_MASK) == '0);

    // Writing zero to the enable register silences the line.
    assert_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enab_wr && reg_wdata == '0) |=> !irq_o);

    // Out of reset both registers are zero, so the line is low.
    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (status == '0 && enable == '0));

endmodule

// File: tb/test_mac_irq_ctrl.sv
module test_mac_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  ev;
    logic        reg_wr;
    logic [7:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        irq_o;

    int n_checks = 0;
    int n_fail   = 0;

    localparam logic [7:0] A_STAT = 8'h3C;
    localparam logic [7:0] A_ENAB = 8'h40;
    localparam logic [7:0] A_OTHR = 8'h44;

    always #5 clk = ~clk;

    mac_irq_ctrl i_mac_irq_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_rx_done   (ev[0]),
        .ev_rx_nodesc (ev[1]),
        .ev_rx_full   (ev[2]),
        .ev_rx_early  (ev[3]),
        .ev_tx_done   (ev[4]),
        .ev_tx_early  (ev[5]),
        .ev_cnt_ovf   (ev[6]),
        .ev_link_chg  (ev[7]),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .irq_o        (irq_o)
    );

    // op: 0 idle, 1 write pending, 2 write enable, 3 write unused offset
    typedef struct packed {
        logic [7:0]  ev;
        logic [1:0]  op;
        logic [15:0] wd;
        logic [15:0] es;
        logic [15:0] ee;
        logic        ei;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{8'h01, 2'd0, 16'h0000, 16'h0001, 16'h0000, 1'b0, 4'd3}, // R3
        '{8'h80, 2'd0, 16'h0000, 16'h0201, 16'h0000, 1'b0, 4'd2}, // R2
        '{8'h20, 2'd0, 16'h0000, 16'h0281, 16'h0000, 1'b0, 4'd2}, // R2
        '{8'h40, 2'd0, 16'h0000, 16'h0381, 16'h0000, 1'b0, 4'd2}, // R2
        '{8'h00, 2'd2, 16'h0017, 16'h0381, 16'h0017, 1'b1, 4'd6}, // R6
        '{8'h00, 2'd1, 16'h0001, 16'h0380, 16'h0017, 1'b0, 4'd4}, // R4
        '{8'h08, 2'd0, 16'h0000, 16'h0388, 16'h0017, 1'b0, 4'd6}, // R6
        '{8'h04, 2'd0, 16'h0000, 16'h038C, 16'h0017, 1'b1, 4'd6}, // R6
        '{8'h00, 2'd1, 16'h0388, 16'h0004, 16'h0017, 1'b1, 4'd4}, // R4
        '{8'h04, 2'd1, 16'h0004, 16'h0004, 16'h0017, 1'b1, 4'd5}, // R5
        '{8'h00, 2'd1, 16'h0004, 16'h0000, 16'h0017, 1'b0, 4'd4}, // R4
        '{8'h00, 2'd2, 16'hFFFF, 16'h0000, 16'h039F, 1'b0, 4'd7}, // R7
        '{8'h10, 2'd0, 16'h0000, 16'h0010, 16'h039F, 1'b1, 4'd6}, // R6
        '{8'h00, 2'd2, 16'h0000, 16'h0010, 16'h0000, 1'b0, 4'd8}, // R8
        '{8'h00, 2'd3, 16'hFFFF, 16'h0010, 16'h0000, 1'b0, 4'd9}, // R9
        '{8'h00, 2'd1, 16'hFFFF, 16'h0000, 16'h0000, 1'b0, 4'd4}, // R4
        '{8'hFF, 2'd0, 16'h0000, 16'h039F, 16'h0000, 1'b0, 4'd2}, // R2
        '{8'h00, 2'd2, 16'h0200, 16'h039F, 16'h0200, 1'b1, 4'd6}, // R6
        '{8'h00, 2'd1, 16'h0C60, 16'h039F, 16'h0200, 1'b1, 4'd7}  // R7
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Read pending, enable and line, away from the clock edge.
    task automatic read_all(output logic [15:0] st, output logic [15:0] en, output logic ln);
        reg_addr = A_STAT; #1; st = reg_rdata;
        reg_addr = A_ENAB; #1; en = reg_rdata;
        ln = irq_o;
    endtask

    // Drive one cycle of stimulus, then return idle at the next falling edge.
    task automatic step(input logic [7:0] e, input logic [1:0] op, input logic [15:0] wd);
        ev        = e;
        reg_wr    = (op != 2'd0);
        reg_addr  = (op == 2'd1) ? A_STAT : (op == 2'd2) ? A_ENAB : A_OTHR;
        reg_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        ev     = '0;
        reg_wr = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [15:0] st, en;
        logic        ln;
        ev = '0; reg_wr = 1'b0; reg_addr = A_STAT; reg_wdata = '0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: state out of reset
        read_all(st, en, ln);
        check("R1 pending", st, 16'h0000);
        check("R1 enable", en, 16'h0000);
        check("R1 irq", {15'd0, ln}, 16'h0000);

        // R2 R3 R4 R5 R6 R7 R8 R9: vector walk
        for (int i = 0; i < NV; i++) begin
            step(VECS[i].ev, VECS[i].op, VECS[i].wd);
            read_all(st, en, ln);
            check($sformatf("R%0d vec%0d pending", VECS[i].rq, i), st, VECS[i].es);
            check($sformatf("R%0d vec%0d enable", VECS[i].rq, i), en, VECS[i].ee);
            check($sformatf("R%0d vec%0d irq", VECS[i].rq, i), {15'd0, ln}, {15'd0, VECS[i].ei});
        end

        // R9: an unused offset reads zero while both registers are nonzero
        reg_addr = A_OTHR; #1;
        check("R9 unused read", reg_rdata, 16'h0000);
        reg_addr = 8'h3E; #1;
        check("R9 near-offset read", reg_rdata, 16'h0000);

        // R1: reset mid-run clears everything
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        read_all(st, en, ln);
        check("R1 re-reset pending", st, 16'h0000);
        check("R1 re-reset enable", en, 16'h0000);
        check("R1 re-reset irq", {15'd0, ln}, 16'h0000);

        // R5: the handshake loses no event that arrives between read and write-back
        step(8'h01, 2'd0, 16'h0000);
        read_all(st, en, ln);
        step(8'h10, 2'd1, st);
        read_all(st, en, ln);
        check("R5 late event survives", st, 16'h0010);

        // R6: the line rises one cycle after an event whose bit is enabled
        step(8'h00, 2'd2, 16'h0002);
        read_all(st, en, ln);
        check("R6 not yet", {15'd0, ln}, 16'h0000);
        step(8'h02, 2'd0, 16'h0000);
        read_all(st, en, ln);
        check("R6 event raises", {15'd0, ln}, 16'h0001);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule